// File: doc/BRIEF.md
# Interrupt Status Register Block

This block gathers the two interrupt sources of a storage port and presents them through a small word-addressed register window. The sources are a level from the attached drive and an error indication from the port's DMA memory path. Each source sets a sticky pending bit. Software enables sources by writing ones to an enable-set word and acknowledges them by writing ones to a clear word. A single interrupt line is raised whenever an enabled source is pending.

Reads of the drive's status byte are also watched. When such a read returns a byte whose busy flag is low, every pending bit is dropped. This means a routine status poll doubles as the acknowledge.

When the memory error first latches, the failing bus address (64 bits) is frozen into two read-only words at the bottom of the window. That value stays put until the error bit is cleared, so the first fault is preserved for the handler.

Top module: `intr_regs`

## Requirements
- R1: After reset, the pending bits, the enable bits, the error address words and `irqOut` are all zero.
- R2: A high `devIrq` sets pending bit 0 at the next clock edge, and a high `memErr` sets pending bit 1 at the next clock edge. Both bits read back in bits [1:0] of word offset 3, and the upper bits of that word read as zero.
- R3: A write to word offset 7 clears each pending bit whose data bit is 1 and leaves bits written with 0 unchanged. A clear beats a source that is high in the same cycle; a source that is still high sets its bit again one cycle later.
- R4: A write to word offset 5 sets each enable bit whose data bit is 1. A 0 data bit leaves that enable unchanged. The enables read back in bits [1:0] of word offset 5.
- R5: `irqOut` is high exactly when some pending bit has its enable set. A disabled source still shows its pending bit in word offset 3.
- R6: A `devStatRd` pulse with `devStatByte` bit 7 (busy) low clears both pending bits at that edge. With bit 7 high it has no effect.
- R7: When `memErr` is high while pending bit 1 is low, `errAddr` is captured. Bits [31:0] read at word offset 0 and bits [63:32] at word offset 1. Further errors leave the capture unchanged until bit 1 has been cleared.
- R8: Writes to word offsets 0, 1, 2, 3, 4 and 6 change no state. Reads of word offsets 2, 4, 6 and 7 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe, one cycle per write |
| addr | input | ADDR_W | Word offset for reads and writes |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Read data for `addr`, combinational |
| devIrq | input | 1 | Interrupt level from the drive |
| memErr | input | 1 | DMA memory/bus error indication |
| errAddr | input | 2*DATA_W | Bus address of the current DMA access |
| devStatRd | input | 1 | Strobe: drive status byte is being read |
| devStatByte | input | 8 | Drive status byte returned by that read |
| irqOut | output | 1 | Interrupt request to the host |

## Verification
The checker watches the cycle-level rules on every edge:
- a clear, whether by write or by an idle status read, beats a source in the same cycle;
- an uncleared source always latches;
- enables never drop without reset;
- the line stays low with no enables;
- the captured error address cannot move while bit 1 is pending.

Only the bench scenarios show the data-dependent effects:
- the exact readback values of each word;
- the per-bit effect of every enable and clear pattern on the line;
- the re-latch of a held source one cycle after its clear;
- that a busy status read and writes to other offsets change nothing.

// File: rtl/intr_regs_pkg.sv
package intr_regs_pkg;
  localparam int NUM_SRC    = 2;
  localparam int DEV_IDX    = 0;
  localparam int ERR_IDX    = 1;
  localparam int BUSY_BIT   = 7;
  localparam int OFS_ERR_LO = 0;
  localparam int OFS_ERR_HI = 1;
  localparam int OFS_STATUS = 3;
  localparam int OFS_ENSET  = 5;
  localparam int OFS_CLEAR  = 7;

  typedef struct packed {
    logic [NUM_SRC-1:0] setEn;
    logic [NUM_SRC-1:0] clrPend;
  } strobe_t;
endpackage

// File: rtl/intr_regs_ctrl.sv
module intr_regs_ctrl
  import intr_regs_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input  logic                 wrEn,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wrData,
  input  logic                 devStatRd,
  input  logic [7:0]           devStatByte,
  output strobe_t              strobes
);
  logic ackRead;
  logic hitSet;
  logic hitClr;

  assign ackRead = devStatRd && !devStatByte[BUSY_BIT];
  assign hitSet  = wrEn && (addr == ADDR_W'(OFS_ENSET));
  assign hitClr  = wrEn && (addr == ADDR_W'(OFS_CLEAR));

  always_comb begin
    strobes.setEn   = hitSet ? wrData[NUM_SRC-1:0] : '0;
    strobes.clrPend = (hitClr ? wrData[NUM_SRC-1:0] : '0) | {NUM_SRC{ackRead}};
  end
endmodule

// File: rtl/intr_regs_dp.sv
module intr_regs_dp
  import intr_regs_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32,
  parameter int ERR_W  = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strobes,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic [ERR_W-1:0]   errAddrIn,
  input  logic [ADDR_W-1:0]  addr,
  output logic [NUM_SRC-1:0] pendingQ,
  output logic [NUM_SRC-1:0] enableQ,
  output logic [ERR_W-1:0]   errAddrQ,
  output logic [DATA_W-1:0]  rdData,
  output logic               irqOut
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : gSrc
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pendingQ[i] <= 1'b0;
        enableQ[i]  <= 1'b0;
      end else begin
        if (strobes.clrPend[i]) pendingQ[i] <= 1'b0;
        else if (srcIn[i])      pendingQ[i] <= 1'b1;
        if (strobes.setEn[i])   enableQ[i]  <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) errAddrQ <= '0;
    else if (srcIn[ERR_IDX] && !pendingQ[ERR_IDX]) errAddrQ <= errAddrIn;
  end

  assign irqOut = |(pendingQ & enableQ);

  always_comb begin
    rdData = '0;
    case (int'(addr))
      OFS_ERR_LO: rdData = errAddrQ[DATA_W-1:0];
      OFS_ERR_HI: rdData = errAddrQ[ERR_W-1:DATA_W];
      OFS_STATUS: rdData = DATA_W'(pendingQ);
      OFS_ENSET:  rdData = DATA_W'(enableQ);
      default:    rdData = '0;
    endcase
  end
endmodule

// File: rtl/intr_regs.sv
module intr_regs
  import intr_regs_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wrData,
  output logic [DATA_W-1:0]   rdData,
  input  logic                devIrq,
  input  logic                memErr,
  input  logic [2*DATA_W-1:0] errAddr,
  input  logic                devStatRd,
  input  logic [7:0]          devStatByte,
  output logic                irqOut
);
  localparam int ERR_W = 2 * DATA_W;

  strobe_t            strobes;
  logic [NUM_SRC-1:0] srcIn;
  logic [NUM_SRC-1:0] pendingQ;
  logic [NUM_SRC-1:0] enableQ;
  logic [ERR_W-1:0]   errAddrQ;

  always_comb begin
    srcIn          = '0;
    srcIn[DEV_IDX] = devIrq;
    srcIn[ERR_IDX] = memErr;
  end

  intr_regs_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uCtrl (
    .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .devStatRd(devStatRd), .devStatByte(devStatByte), .strobes(strobes)
  );

  intr_regs_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ERR_W(ERR_W)) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .srcIn(srcIn),
    .errAddrIn(errAddr), .addr(addr), .pendingQ(pendingQ), .enableQ(enableQ),
    .errAddrQ(errAddrQ), .rdData(rdData), .irqOut(irqOut)
  );
endmodule

// File: rtl/intr_regs_chk.sv
module intr_regs_chk
  import intr_regs_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input logic                clk,
  input logic                rstN,
  input logic                wrEn,
  input logic [ADDR_W-1:0]   addr,
  input logic [DATA_W-1:0]   wrData,
  input logic                devIrq,
  input logic                memErr,
  input logic                devStatRd,
  input logic [7:0]          devStatByte,
  input logic                irqOut,
  input logic [NUM_SRC-1:0]  pendingQ,
  input logic [NUM_SRC-1:0]  enableQ,
  input logic [2*DATA_W-1:0] errAddrQ
);
  logic idleRead;
  logic clrWr0;
  logic clrWr1;
  assign idleRead = devStatRd && !devStatByte[BUSY_BIT];
  assign clrWr0   = wrEn && (addr == ADDR_W'(OFS_CLEAR)) && wrData[DEV_IDX];
  assign clrWr1   = wrEn && (addr == ADDR_W'(OFS_CLEAR)) && wrData[ERR_IDX];

  AST_CLEAR_BEATS_SRC: assert property (@(posedge clk) disable iff (!rstN)
    clrWr0 |=> !pendingQ[DEV_IDX]); // R3
  AST_DEV_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    (devIrq && !clrWr0 && !idleRead) |=> pendingQ[DEV_IDX]); // R2
  AST_ERR_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    (memErr && !clrWr1 && !idleRead) |=> pendingQ[ERR_IDX]); // R2
  AST_IDLE_READ_ACK: assert property (@(posedge clk) disable iff (!rstN)
    idleRead |=> (pendingQ == '0)); // R6
  AST_ENABLE0_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    enableQ[DEV_IDX] |=> enableQ[DEV_IDX]); // R4
  AST_ENABLE1_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    enableQ[ERR_IDX] |=> enableQ[ERR_IDX]); // R4
  AST_NO_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (enableQ == '0) |-> !irqOut); // R5
  AST_ERR_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    pendingQ[ERR_IDX] |=> $stable(errAddrQ)); // R7
endmodule

bind intr_regs intr_regs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uChk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
  .devIrq(devIrq), .memErr(memErr), .devStatRd(devStatRd),
  .devStatByte(devStatByte), .irqOut(irqOut), .pendingQ(pendingQ),
  .enableQ(enableQ), .errAddrQ(errAddrQ)
);

// File: tb/sim_intr_regs.sv
`timescale 1ns/1ps
module sim_intr_regs;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              wrEn = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wrData = '0;
  logic [DATA_W-1:0] rdData;
  logic              devIrq = 1'b0;
  logic              memErr = 1'b0;
  logic [63:0]       errAddr = '0;
  logic              devStatRd = 1'b0;
  logic [7:0]        devStatByte = '0;
  logic              irqOut;

  int  checks = 0;
  int  fails = 0;
  bit  done = 1'b0;

  always #5 clk = ~clk;

  intr_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .devIrq(devIrq), .memErr(memErr), .errAddr(errAddr),
    .devStatRd(devStatRd), .devStatByte(devStatByte), .irqOut(irqOut)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [DATA_W-1:0] d);
    addr = a[ADDR_W-1:0];
    wrData = d;
    wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    wrData = '0;
  endtask

  task automatic rd(input int a, output logic [DATA_W-1:0] v);
    addr = a[ADDR_W-1:0];
    #1;
    v = rdData;
  endtask

  task automatic pulseSrc(input logic [1:0] s, input logic [63:0] ea);
    devIrq = s[0];
    memErr = s[1];
    errAddr = ea;
    @(negedge clk);
    devIrq = 1'b0;
    memErr = 1'b0;
  endtask

  task automatic statRead(input logic [7:0] b);
    devStatByte = b;
    devStatRd = 1'b1;
    @(negedge clk);
    devStatRd = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [DATA_W-1:0] v;
    logic [DATA_W-1:0] w;
    // Sweep every enable, source and clear pattern
    for (int en = 0; en < 4; en++) begin
      doReset();
      rd(3, v); chk("R1 status", v, 0);
      rd(5, v); chk("R1 enable", v, 0);
      rd(0, v); chk("R1 errLo", v, 0);
      rd(1, v); chk("R1 errHi", v, 0);
      chk("R1 irqOut", irqOut, 0);
      wr(5, en);
      wr(5, 0);
      rd(5, v); chk("R4 enable readback", v, en);
      for (int src = 0; src < 4; src++) begin
        for (int clr = 0; clr < 4; clr++) begin
          pulseSrc(src[1:0], 64'h0);
          rd(3, v); chk("R2 latch", v, src);
          chk("R5 irq after latch", irqOut, |(src[1:0] & en[1:0]));
          wr(7, DATA_W'(clr) | 32'hFFFF_FFFC);
          rd(3, v); chk("R3 partial clear", v, src & ~clr & 3);
          chk("R5 irq after clear", irqOut, |(src[1:0] & ~clr[1:0] & en[1:0]));
          wr(7, 3);
          rd(3, v); chk("R3 full clear", v, 0);
        end
      end
    end

    // Held source: clear wins, then re-latches
    doReset();
    devIrq = 1'b1;
    @(negedge clk);
    wr(7, 1);
    rd(3, v); chk("R3 clear beats held source", v, 0);
    @(negedge clk);
    rd(3, v); chk("R3 re-latch next cycle", v, 1);
    devIrq = 1'b0;
    wr(7, 3);

    // Status-byte read acknowledge
    pulseSrc(2'b11, 64'h0);
    statRead(8'h80);
    rd(3, v); chk("R6 busy read keeps bits", v, 3);
    statRead(8'h7F);
    rd(3, v); chk("R6 idle read clears", v, 0);
    pulseSrc(2'b01, 64'h0);
    statRead(8'h00);
    rd(3, v); chk("R6 idle read clears dev", v, 0);

    // Error address capture and hold
    doReset();
    pulseSrc(2'b10, 64'h1234_5678_9ABC_DEF0);
    rd(0, v); chk("R7 errLo first", v, 32'h9ABC_DEF0);
    rd(1, v); chk("R7 errHi first", v, 32'h1234_5678);
    pulseSrc(2'b10, 64'hAAAA_BBBB_CCCC_DDDD);
    rd(0, v); chk("R7 errLo held", v, 32'h9ABC_DEF0);
    rd(1, v); chk("R7 errHi held", v, 32'h1234_5678);
    wr(7, 2);
    pulseSrc(2'b10, 64'hAAAA_BBBB_CCCC_DDDD);
    rd(0, v); chk("R7 errLo recapture", v, 32'hCCCC_DDDD);
    rd(1, v); chk("R7 errHi recapture", v, 32'hAAAA_BBBB);

    // Writes to other offsets change nothing; unused reads return zero
    pulseSrc(2'b01, 64'h0);
    wr(0, 32'hFFFF_FFFF);
    wr(1, 32'hFFFF_FFFF);
    wr(2, 32'hFFFF_FFFF);
    wr(3, 32'h0);
    wr(4, 32'hFFFF_FFFF);
    wr(6, 32'hFFFF_FFFF);
    rd(3, v); chk("R8 status untouched", v, 3);
    rd(5, v); chk("R8 enable untouched", v, 0);
    chk("R8 irq stays low", irqOut, 0);
    rd(0, v); chk("R8 errLo untouched", v, 32'hCCCC_DDDD);
    rd(1, w); chk("R8 errHi untouched", w, 32'hAAAA_BBBB);
    rd(2, v); chk("R8 read word 2", v, 0);
    rd(4, v); chk("R8 read word 4", v, 0);
    rd(6, v); chk("R8 read word 6", v, 0);
    rd(7, v); chk("R8 read word 7", v, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule